// File: doc/BRIEF.md
# Filtered Brown-Out Reset Controller

This block turns the flag of an external analog supply comparator into a clean internal reset request. The comparator reports whether the supply sits below the threshold the block selects for it. The raw flag is first passed through a synchronizer. A persistence filter then accepts a change of state only once it has held for a programmable number of clock cycles, so short spikes on the supply never reach the reset tree. The same filter length applies when the reset is raised and when it is released.

Two configuration values arrive from a configuration byte: an enable and a 2-bit level select. Both are captured only while the power-on reset is asserted and then stay fixed. The level select is driven back to the comparator as a threshold code. The three codes map to falling and rising trip points of about 2.9/3.1 V, 3.4/3.65 V and 3.9/4.2 V. The comparator provides the hysteresis between them, which is 200, 250 and 300 mV. The fourth code is reserved and falls back to the lowest level. In halt mode the block is forced inactive and requests no reset. The reset request fans out to a parameterized set of reset domains, and it never drives the domain of the power-on detector or the domain that holds this block.

Top module: `bor_guard_top`

## Requirements
- R1: While `por_rst_ni` is low and on the first cycle after it rises, `bor_rst_o` is 0 and `dom_rst_o` is all zeros.
- R2: `level_code_o` is captured from `cfg_level_i` only on clock edges where `por_rst_ni` is low. Codes 2'b00, 2'b01 and 2'b10 pass unchanged, and the reserved 2'b11 becomes 2'b00. Changes on `cfg_level_i` after reset have no effect.
- R3: `cfg_enable_i` is captured only on clock edges where `por_rst_ni` is low. When the captured value is 0, `bor_rst_o` stays 0 whatever the comparator does. Later changes of `cfg_enable_i` have no effect.
- R4: When `cmp_low_i` (1 = supply low) rises and stays high, `bor_rst_o` rises on the (FILT_CYC+2)-th rising clock edge, counting the first edge that samples the new value. Two of those edges are spent in the two synchronizer stages.
- R5: A high pulse on `cmp_low_i` that lasts FILT_CYC-1 cycles or less leaves `bor_rst_o` at 0. A pulse of exactly FILT_CYC cycles raises it. Any return of the flag to the accepted state before the full count restarts the count from zero.
- R6: When `cmp_low_i` falls and stays low while the reset is asserted, `bor_rst_o` falls on the (FILT_CYC+2)-th rising edge, with the same timing as R4.
- R7: `bor_rst_o` stays 1 for as long as the filtered supply-low state persists.
- R8: On any clock edge where `halt_i` is 1, the filter is cleared, and `bor_rst_o` is 0 after that edge. After halt ends with the flag still high, the reset rises again only on the FILT_CYC-th edge after the last halt edge.
- R9: `dom_rst_o` equals {NUM_DOMAINS{`bor_rst_o`}}, except that bit POR_DOM (default 0) and bit SELF_DOM (default 1) are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| por_rst_ni | input | 1 | Power-on reset, active low, synchronous. The configuration is captured while it is low |
| cmp_low_i | input | 1 | Raw comparator flag, 1 = supply below the selected threshold |
| cfg_level_i | input | 2 | Level select from the configuration byte |
| cfg_enable_i | input | 1 | Enable from the configuration byte |
| halt_i | input | 1 | Halt mode active |
| level_code_o | output | 2 | Threshold code driven to the analog comparator |
| bor_rst_o | output | 1 | Filtered brown-out reset request |
| dom_rst_o | output | NUM_DOMAINS | Per-domain reset requests |

## Verification
On every cycle the assertions check the following: the threshold code is never the reserved value and never moves after reset; a disabled block stays quiet; every rise or fall of the reset is preceded by a full count on the synchronized flag (or by halt, for a fall); the counter stays in range; and the domain fan-out keeps the protected domains clear. Only the bench scenarios can show the exact edge on which the reset rises or falls and the boundary between a rejected pulse of FILT_CYC-1 cycles and an accepted one of FILT_CYC cycles. The same holds for the full requalification after halt, and for the fact that configuration changes after reset are ignored. A random mix of comparator runs and halt windows is compared tick by tick against a reference model in the bench.

// File: rtl/bor_pkg.sv
package bor_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } bor_level_e;

  // Reserved select value falls back to the lowest trip point.
  function automatic bor_level_e decode_level(input logic [1:0] sel);
    bor_level_e lvl;
    case (sel)
      2'b01:   lvl = LVL_MID;
      2'b10:   lvl = LVL_HIGH;
      default: lvl = LVL_LOW;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/bor_sync.sv
module bor_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bor_persist_filter.sv
module bor_persist_filter #(
  parameter int FILT_CYC = 50,
  parameter int CNT_W    = $clog2(FILT_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             sample_i,
  output logic             state_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYC - 1);

  logic             state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !active_i) begin
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else if (sample_i == state_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      state_q <= sample_i;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/bor_domain_fanout.sv
module bor_domain_fanout #(
  parameter int NUM_DOMAINS = 4,
  parameter int POR_DOM     = 0,
  parameter int SELF_DOM    = 1
) (
  input  logic                   req_i,
  output logic [NUM_DOMAINS-1:0] dom_o
);
  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    if (d == POR_DOM || d == SELF_DOM) begin : g_keep
      assign dom_o[d] = 1'b0;
    end else begin : g_drive
      assign dom_o[d] = req_i;
    end
  end
endmodule

// File: rtl/bor_guard_top.sv
module bor_guard_top
  import bor_pkg::*;
#(
  parameter int FILT_CYC    = 50,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_DOMAINS = 4,
  parameter int POR_DOM     = 0,
  parameter int SELF_DOM    = 1
) (
  input  logic                   clk_i,
  input  logic                   por_rst_ni,
  input  logic                   cmp_low_i,
  input  logic [1:0]             cfg_level_i,
  input  logic                   cfg_enable_i,
  input  logic                   halt_i,
  output logic [1:0]             level_code_o,
  output logic                   bor_rst_o,
  output logic [NUM_DOMAINS-1:0] dom_rst_o
);
  localparam int CNT_W = $clog2(FILT_CYC + 1);

  bor_level_e       lvl_q;
  logic             en_q;
  logic             sync_low;
  logic             active;
  logic             filt_state;
  logic [CNT_W-1:0] filt_cnt;

  // Configuration is only taken while power-on reset holds.
  always_ff @(posedge clk_i) begin
    if (!por_rst_ni) begin
      en_q  <= cfg_enable_i;
      lvl_q <= decode_level(cfg_level_i);
    end
  end

  assign level_code_o = lvl_q;
  assign active       = en_q && !halt_i;

  bor_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (por_rst_ni),
    .d_i    (cmp_low_i),
    .q_o    (sync_low)
  );

  bor_persist_filter #(.FILT_CYC(FILT_CYC), .CNT_W(CNT_W)) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (por_rst_ni),
    .active_i (active),
    .sample_i (sync_low),
    .state_o  (filt_state),
    .cnt_o    (filt_cnt)
  );

  assign bor_rst_o = filt_state;

  bor_domain_fanout #(
    .NUM_DOMAINS (NUM_DOMAINS),
    .POR_DOM     (POR_DOM),
    .SELF_DOM    (SELF_DOM)
  ) u_fan (
    .req_i (filt_state),
    .dom_o (dom_rst_o)
  );
endmodule

// File: rtl/bor_guard_chk.sv
module bor_guard_chk #(
  parameter int FILT_CYC    = 50,
  parameter int NUM_DOMAINS = 4,
  parameter int POR_DOM     = 0,
  parameter int SELF_DOM    = 1,
  parameter int CNT_W       = 6
) (
  input logic                   clk_i,
  input logic                   por_rst_ni,
  input logic                   halt_i,
  input logic                   en_q,
  input logic                   sync_low,
  input logic [CNT_W-1:0]       filt_cnt,
  input logic [1:0]             level_code_o,
  input logic                   bor_rst_o,
  input logic [NUM_DOMAINS-1:0] dom_rst_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYC - 1);

  // R2
  lvl_legal_chk: assert property (@(posedge clk_i) disable iff (!por_rst_ni)
    level_code_o != 2'b11);

  // R2
  lvl_hold_chk: assert property (@(posedge clk_i) disable iff (!por_rst_ni)
    $past(por_rst_ni) |-> $stable(level_code_o));

  // R3
  dis_quiet_chk: assert property (@(posedge clk_i) disable iff (!por_rst_ni)
    !en_q |-> !bor_rst_o);

  // R4
  rise_qual_chk: assert property (@(posedge clk_i) disable iff (!por_rst_ni)
    $rose(bor_rst_o) |-> ($past(sync_low) && $past(filt_cnt) == LAST && !$past(halt_i)));

  // R6
  fall_qual_chk: assert property (@(posedge clk_i) disable iff (!por_rst_ni)
    $fell(bor_rst_o) |-> ($past(halt_i) || (!$past(sync_low) && $past(filt_cnt) == LAST)));

  // R5
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!por_rst_ni)
    filt_cnt <= LAST);

  // R8
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!por_rst_ni)
    halt_i |=> !bor_rst_o);

  // R9
  dom_map_chk: assert property (@(posedge clk_i) disable iff (!por_rst_ni)
    (!dom_rst_o[POR_DOM] && !dom_rst_o[SELF_DOM] &&
     $countones(dom_rst_o) == (bor_rst_o ? NUM_DOMAINS - 2 : 0)));
endmodule

bind bor_guard_top bor_guard_chk #(
  .FILT_CYC    (FILT_CYC),
  .NUM_DOMAINS (NUM_DOMAINS),
  .POR_DOM     (POR_DOM),
  .SELF_DOM    (SELF_DOM),
  .CNT_W       (CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .por_rst_ni   (por_rst_ni),
  .halt_i       (halt_i),
  .en_q         (en_q),
  .sync_low     (sync_low),
  .filt_cnt     (filt_cnt),
  .level_code_o (level_code_o),
  .bor_rst_o    (bor_rst_o),
  .dom_rst_o    (dom_rst_o)
);

// File: tb/test_bor_guard_top.sv
module test_bor_guard_top;
  localparam int F = 12;

  logic       clk = 1'b0;
  logic       por_rst_ni = 1'b0;
  logic       cmp_low_i = 1'b0;
  logic [1:0] cfg_level_i = 2'b00;
  logic       cfg_enable_i = 1'b1;
  logic       halt_i = 1'b0;
  logic [1:0] level_code_o;
  logic       bor_rst_o;
  logic [3:0] dom_rst_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  bit       m_en;
  bit [1:0] m_lvl;
  bit       m_h1, m_h2, m_st;
  int       m_cnt;

  always #2 clk = ~clk;

  bor_guard_top #(.FILT_CYC(F)) i_bor_guard_top (
    .clk_i        (clk),
    .por_rst_ni   (por_rst_ni),
    .cmp_low_i    (cmp_low_i),
    .cfg_level_i  (cfg_level_i),
    .cfg_enable_i (cfg_enable_i),
    .halt_i       (halt_i),
    .level_code_o (level_code_o),
    .bor_rst_o    (bor_rst_o),
    .dom_rst_o    (dom_rst_o)
  );

  function automatic bit [1:0] exp_level(input bit [1:0] sel);
    return (sel == 2'b11) ? 2'b00 : sel;
  endfunction

  function automatic bit [3:0] exp_dom(input bit req);
    return req ? 4'b1100 : 4'b0000;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: model update at the edge, compare at the falling edge.
  task automatic tick();
    @(posedge clk);
    if (!por_rst_ni) begin
      m_en = cfg_enable_i; m_lvl = exp_level(cfg_level_i);
      m_h1 = 0; m_h2 = 0; m_st = 0; m_cnt = 0;
    end else begin
      if (!m_en || halt_i) begin m_st = 0; m_cnt = 0; end
      else if (m_h2 == m_st) m_cnt = 0;
      else if (m_cnt == F - 1) begin m_st = m_h2; m_cnt = 0; end
      else m_cnt++;
      m_h2 = m_h1; m_h1 = cmp_low_i;
    end
    @(negedge clk);
    chk("R4/R6/R7/R8 model", int'(bor_rst_o), int'(m_st));
    chk("R9 model", int'(dom_rst_o), int'(exp_dom(m_st)));
    chk("R2 model", int'(level_code_o), int'(m_lvl));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_reset(input bit [1:0] lvl, input bit en);
    por_rst_ni = 0; cfg_level_i = lvl; cfg_enable_i = en;
    cmp_low_i = 0; halt_i = 0;
    ticks(3);
    chk("R1 reset bor", int'(bor_rst_o), 0);
    chk("R1 reset dom", int'(dom_rst_o), 0);
    por_rst_ni = 1;
    tick();
    chk("R1 first cycle", int'(bor_rst_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);

    // R2: level mapping, including reserved code
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s), 1'b1);
      chk("R2 level code", int'(level_code_o), int'(exp_level(2'(s))));
    end
    cfg_level_i = 2'b01; ticks(3);
    chk("R2 post-reset change ignored", int'(level_code_o), 0);

    // R4: exact assertion edge
    do_reset(2'b10, 1'b1);
    cmp_low_i = 1;
    ticks(F + 1);
    chk("R4 not before F+2 edges", int'(bor_rst_o), 0);
    tick();
    chk("R4 asserted at F+2 edges", int'(bor_rst_o), 1);
    chk("R9 domains driven", int'(dom_rst_o), 4'b1100);

    // R7: holds while low
    ticks(5 * F);
    chk("R7 held", int'(bor_rst_o), 1);

    // R6: symmetric release
    cmp_low_i = 0;
    ticks(F + 1);
    chk("R6 still held at F+1", int'(bor_rst_o), 1);
    tick();
    chk("R6 released at F+2", int'(bor_rst_o), 0);
    chk("R9 domains clear", int'(dom_rst_o), 0);

    // R5: pulse of F-1 rejected, restart of count, pulse of F accepted
    cmp_low_i = 1; ticks(F - 1); cmp_low_i = 0; ticks(2 * F);
    chk("R5 short pulse rejected", int'(bor_rst_o), 0);
    cmp_low_i = 1; ticks(F - 2); cmp_low_i = 0; tick();
    cmp_low_i = 1; ticks(F - 2); cmp_low_i = 0; ticks(2 * F);
    chk("R5 count restarts", int'(bor_rst_o), 0);
    cmp_low_i = 1; ticks(F); cmp_low_i = 0; ticks(2);
    chk("R5 full pulse accepted", int'(bor_rst_o), 1);
    ticks(2 * F);

    // R8: halt clears and requalifies
    cmp_low_i = 1; ticks(F + 4);
    chk("R8 pre-halt asserted", int'(bor_rst_o), 1);
    halt_i = 1; tick();
    chk("R8 cleared by halt", int'(bor_rst_o), 0);
    ticks(F + 3);
    chk("R8 quiet during halt", int'(bor_rst_o), 0);
    halt_i = 0;
    ticks(F - 1);
    chk("R8 requalify not early", int'(bor_rst_o), 0);
    tick();
    chk("R8 requalified", int'(bor_rst_o), 1);

    // R3: disabled block never resets; enable change ignored
    do_reset(2'b00, 1'b0);
    cfg_enable_i = 1; cmp_low_i = 1;
    ticks(4 * F);
    chk("R3 disabled stays quiet", int'(bor_rst_o), 0);

    // Random mix checked against the model
    for (int r = 0; r < 6; r++) begin
      do_reset(2'($urandom_range(0, 3)), 1'($urandom_range(0, 5) != 0));
      for (int seg = 0; seg < 40; seg++) begin
        cmp_low_i = 1'($urandom_range(0, 1));
        halt_i    = ($urandom_range(0, 9) == 0);
        ticks($urandom_range(1, 2 * F + 2));
      end
      halt_i = 0;
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule